// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer

This block produces the instruction fetch address for a 32-bit RISC core whose branches have one delay slot. It keeps three addresses: the current PC, the next PC and the previous PC. Each time an instruction retires, the current PC moves to the previous register and the next PC becomes current. A taken branch does not redirect the fetch at once. It loads its target into the next-PC register and marks the following fetch as a delay-slot instruction. So the instruction after the branch still runs, and the target is fetched after it.

The block also handles software breakpoints. When the fetch address matches a breakpoint, it raises a halt request for one cycle and holds the PC. When execution resumes, the same address is allowed to retire without a second halt. A redirect input stands in for exception entry: it loads a vector address. An advance-enable input freezes the whole sequencer while the pipeline stalls.

Top module: `pcseq_top`

## Requirements
- R1: While reset is held and on the first cycle after it, fetch_addr is 0x0, prev_pc is 0x0, in_delay_slot is 0 and halt_req is 0. The first retirement after reset fetches 0x4.
- R2: A retirement without a branch advances fetch_addr by 4. After the clock edge, prev_pc equals the fetch address that retired.
- R3: When an instruction at address A retires with br_taken=1 and target T, the next fetch is A+4 with in_delay_slot=1. The retirement after that fetches T with in_delay_slot=0, and the one after that fetches T+4.
- R4: Bits [1:0] of fetch_addr are always 0, including after a redirect to an unaligned vector.
- R5: With adv_en=1, redir_valid=0, bkpt_hit=1 and the step-over flag clear, halt_req is 1 in that cycle. After the edge, fetch_addr, prev_pc and in_delay_slot are unchanged, and a br_taken given in that cycle has no effect.
- R6: After a halt, the next advancing cycle at the same address gives halt_req=0 even when bkpt_hit=1, and the PC advances. A later breakpoint match, after a retirement without a halt, halts again. The step-over flag survives stalls.
- R7: With adv_en=1 and redir_valid=1, the block ignores bkpt_hit and br_taken. After the edge, the fetch address is the vector with bits [1:0] cleared and in_delay_slot=0. The next retirement fetches the vector plus 4, and the step-over flag is cleared.
- R8: With adv_en=0, halt_req is 0, and fetch_addr, prev_pc and in_delay_slot stay unchanged whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv_en | input | 1 | Pipeline may advance this cycle |
| br_taken | input | 1 | The retiring instruction is a taken branch |
| br_target | input | AW | Branch target address |
| redir_valid | input | 1 | Exception-style redirect request |
| redir_vector | input | AW | Redirect vector address |
| bkpt_hit | input | 1 | The current fetch address matches a breakpoint |
| fetch_addr | output | AW | Word-aligned fetch address |
| in_delay_slot | output | 1 | The current instruction sits in a delay slot |
| prev_pc | output | AW | Address of the last retired instruction |
| halt_req | output | 1 | Breakpoint halt request for this cycle |

## Verification
The hardest case to reach from the ports is the step-over flag meeting other events. A stall between the halt and the resume must keep the flag set. A redirect must clear it. A branch given during the halt cycle must leave no trace. The bench drives the breakpoint match from its own model of the fetch address and sweeps breakpoints across branch targets and delay slots. It puts stalls and redirects between the halt and the resume and checks both halt_req and the address chain on every cycle.

// File: rtl/pcseq_pkg.sv
// Shared types and constants for the delay-slot PC sequencer.
// Assumes fixed 4-byte instructions.
package pcseq_pkg;
    localparam int unsigned INSN_BYTES = 4;
    localparam int unsigned ALIGN_BITS = $clog2(INSN_BYTES);

    // One action per cycle, chosen by the controller.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_HALT  = 2'd2,
        ACT_REDIR = 2'd3
    } pc_act_e;
endpackage

// File: rtl/pcseq_ctrl.sv
// Picks the cycle action: hold, retire, breakpoint halt or redirect.
// Keeps the step-over flag, so that a reported breakpoint is passed on resume.
// Assumes bkpt_hit refers to the fetch address shown in the same cycle.
module pcseq_ctrl
    import pcseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    adv_en,
    input  logic    redir_valid,
    input  logic    bkpt_hit,
    output pc_act_e act,
    output logic    halt_req
);
    logic step_over_q;

    // Priority: stall, then redirect, then breakpoint, then normal retire.
    always_comb begin
        if (!adv_en)
            act = ACT_HOLD;
        else if (redir_valid)
            act = ACT_REDIR;
        else if (bkpt_hit && !step_over_q)
            act = ACT_HALT;
        else
            act = ACT_STEP;
    end

    assign halt_req = (act == ACT_HALT);

    // Step-over flag: set by a halt, cleared by any fetch that goes ahead.
    always_ff @(posedge clk) begin
        if (!rst_n)
            step_over_q <= 1'b0;
        else begin
            case (act)
                ACT_HALT:            step_over_q <= 1'b1;
                ACT_STEP, ACT_REDIR: step_over_q <= 1'b0;
                default:             step_over_q <= step_over_q;
            endcase
        end
    end

    AST_HALT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> !halt_req); // R6
endmodule

// File: rtl/pcseq_chain.sv
// Holds the current, next and previous PC and the delay-slot flag.
// A taken branch loads its target into the next PC.
// The delay-slot instruction is therefore fetched before the target.
module pcseq_chain
    import pcseq_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pc_act_e       act,
    input  logic          br_taken,
    input  logic [AW-1:0] br_target,
    input  logic [AW-1:0] redir_vector,
    output logic [AW-1:0] cur_pc,
    output logic [AW-1:0] prev_pc,
    output logic          in_delay
);
    localparam logic [AW-1:0] STRIDE   = AW'(INSN_BYTES);
    localparam logic [AW-1:0] RESET_PC = '0;

    logic [AW-1:0] nxt_pc;

    // Address chain update for each action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_pc   <= RESET_PC;
            nxt_pc   <= RESET_PC + STRIDE;
            prev_pc  <= RESET_PC;
            in_delay <= 1'b0;
        end else begin
            case (act)
                ACT_STEP: begin
                    prev_pc  <= cur_pc;
                    cur_pc   <= nxt_pc;
                    in_delay <= br_taken;
                    nxt_pc   <= br_taken ? br_target : nxt_pc + STRIDE;
                end
                ACT_REDIR: begin
                    prev_pc  <= cur_pc;
                    cur_pc   <= redir_vector;
                    nxt_pc   <= redir_vector + STRIDE;
                    in_delay <= 1'b0;
                end
                default: begin
                    prev_pc  <= prev_pc;
                    cur_pc   <= cur_pc;
                    nxt_pc   <= nxt_pc;
                    in_delay <= in_delay;
                end
            endcase
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_HOLD) |=> $stable(cur_pc) && $stable(nxt_pc) && $stable(in_delay)); // R8
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_HALT) |=> $stable(cur_pc) && $stable(prev_pc) && $stable(nxt_pc)); // R5
    AST_BRANCH_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_STEP && br_taken) |=> in_delay); // R3
    AST_REDIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_REDIR) |=> !in_delay && cur_pc == $past(redir_vector)); // R7
    AST_PREV_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_STEP) |=> prev_pc == $past(cur_pc)); // R2
endmodule

// File: rtl/pcseq_top.sv
// Delay-slot PC sequencer top level.
// Joins the action controller to the address chain and aligns the fetch address.
// Assumes one instruction retires per advancing cycle.
module pcseq_top
    import pcseq_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_en,
    input  logic          br_taken,
    input  logic [AW-1:0] br_target,
    input  logic          redir_valid,
    input  logic [AW-1:0] redir_vector,
    input  logic          bkpt_hit,
    output logic [AW-1:0] fetch_addr,
    output logic          in_delay_slot,
    output logic [AW-1:0] prev_pc,
    output logic          halt_req
);
    pc_act_e       act;
    logic [AW-1:0] cur_pc;

    pcseq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_en      (adv_en),
        .redir_valid (redir_valid),
        .bkpt_hit    (bkpt_hit),
        .act         (act),
        .halt_req    (halt_req)
    );

    pcseq_chain #(.AW(AW)) u_chain (
        .clk          (clk),
        .rst_n        (rst_n),
        .act          (act),
        .br_taken     (br_taken),
        .br_target    (br_target),
        .redir_vector (redir_vector),
        .cur_pc       (cur_pc),
        .prev_pc      (prev_pc),
        .in_delay     (in_delay_slot)
    );

    // Clear the byte-offset bits before the address goes out.
    generate
        if (ALIGN_BITS > 0) begin : g_align
            assign fetch_addr = {cur_pc[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        end else begin : g_noalign
            assign fetch_addr = cur_pc;
        end
    endgenerate
endmodule

// File: tb/pcseq_top_test.sv
module pcseq_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv_en = 1'b0, br_taken = 1'b0, redir_valid = 1'b0, bkpt_hit = 1'b0;
    logic [31:0] br_target = '0, redir_vector = '0;
    logic [31:0] fetch_addr, prev_pc;
    logic        in_delay_slot, halt_req;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    // Bench model of the address chain.
    logic [31:0] m_cur, m_nxt, m_prev;
    bit          m_dly, m_step;

    always #2 clk = ~clk;

    pcseq_top uut (
        .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .br_taken(br_taken),
        .br_target(br_target), .redir_valid(redir_valid), .redir_vector(redir_vector),
        .bkpt_hit(bkpt_hit), .fetch_addr(fetch_addr), .in_delay_slot(in_delay_slot),
        .prev_pc(prev_pc), .halt_req(halt_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive, check halt before the edge, update the model, check the registers after it.
    task automatic cyc(input bit adv, input bit br, input logic [31:0] tgt,
                       input bit rd, input logic [31:0] vec, input bit hit, input string req);
        bit exp_halt;
        adv_en = adv; br_taken = br; br_target = tgt;
        redir_valid = rd; redir_vector = vec; bkpt_hit = hit;
        #1;
        exp_halt = adv && !rd && hit && !m_step;
        chk({req, " halt"}, {31'd0, halt_req}, {31'd0, exp_halt});
        if (adv) begin
            if (rd) begin
                m_prev = m_cur; m_cur = vec; m_nxt = vec + 32'd4; m_dly = 0; m_step = 0;
            end else if (exp_halt) begin
                m_step = 1;
            end else begin
                m_prev = m_cur; m_cur = m_nxt; m_dly = br;
                m_nxt = br ? tgt : m_nxt + 32'd4; m_step = 0;
            end
        end
        @(posedge clk); #1;
        chk({req, " fetch"}, fetch_addr, m_cur & 32'hFFFF_FFFC);
        chk({req, " prev"}, prev_pc, m_prev);
        chk({req, " delay"}, {31'd0, in_delay_slot}, {31'd0, m_dly});
        chk("R4 low bits", {30'd0, fetch_addr[1:0]}, 32'd0);
    endtask

    task automatic retire(input string req);
        cyc(1, 0, 32'd0, 0, 32'd0, 0, req);
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        if (!done) begin
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, bp;
        m_cur = 0; m_nxt = 4; m_prev = 0; m_dly = 0; m_step = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 fetch", fetch_addr, 32'd0);
        chk("R1 prev", prev_pc, 32'd0);
        chk("R1 delay", {31'd0, in_delay_slot}, 32'd0);
        chk("R1 halt", {31'd0, halt_req}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 after release", fetch_addr, 32'd0);
        retire("R1 first");
        chk("R1 first fetch", fetch_addr, 32'd4);

        // R2 straight-line run
        for (int i = 0; i < 10; i++) retire("R2 seq");
        chk("R2 end", fetch_addr, 32'd44);

        // R3 branch sweep: branch, delay slot, target, target+4
        for (int k = 0; k < 8; k++) begin
            a = fetch_addr;
            cyc(1, 1, 32'h100 + k * 32'h40, 0, 0, 0, "R3 branch");
            chk("R3 slot addr", fetch_addr, a + 32'd4);
            chk("R3 slot flag", {31'd0, in_delay_slot}, 32'd1);
            retire("R3 slot");
            chk("R3 target", fetch_addr, 32'h100 + k * 32'h40);
            retire("R3 after");
            chk("R3 target+4", fetch_addr, 32'h104 + k * 32'h40);
        end

        // R7 / R4 redirect to vectors of every alignment, interrupting a pending branch
        for (int v = 0; v < 8; v++) begin
            cyc(1, 1, 32'h900, 0, 0, 0, "R7 setup");
            cyc(1, 1, 32'h700, 1, 32'h2000 + v, 1, "R7 redirect");
            chk("R7 vector", fetch_addr, (32'h2000 + v) & 32'hFFFF_FFFC);
            chk("R7 delay clear", {31'd0, in_delay_slot}, 32'd0);
            retire("R7 vec+4");
        end

        // R8 stall ignores everything
        a = fetch_addr;
        for (int i = 0; i < 4; i++) cyc(0, 1, 32'h500, i[0], 32'h600, 1, "R8 stall");
        chk("R8 held", fetch_addr, a);

        // R5 / R6 breakpoint sweep at several distances
        for (int d = 0; d < 4; d++) begin
            for (int i = 0; i < d; i++) retire("R6 walk");
            bp = fetch_addr;
            cyc(1, 1, 32'h3000, 0, 0, 1, "R5 halt");
            chk("R5 no move", fetch_addr, bp);
            chk("R5 branch ignored", {31'd0, in_delay_slot}, 32'd0);
            if (d[0]) cyc(0, 0, 0, 0, 0, 1, "R6 stall keeps flag");
            cyc(1, 0, 0, 0, 0, 1, "R6 step over");
            chk("R6 advanced", fetch_addr, bp + 32'd4);
            cyc(1, 0, 0, 0, 0, 1, "R6 rehalt");
            chk("R6 rehalt held", fetch_addr, bp + 32'd4);
            cyc(1, 0, 0, 0, 0, 0, "R6 resume");
        end

        // R7 redirect beats breakpoint and clears step-over
        cyc(1, 0, 0, 0, 0, 1, "R5 halt pre");
        cyc(1, 0, 0, 1, 32'h4000, 1, "R7 over bkpt");
        chk("R7 over bkpt addr", fetch_addr, 32'h4000);
        cyc(1, 0, 0, 0, 0, 1, "R7 flag cleared");

        // R3 breakpoint inside a delay slot
        cyc(1, 1, 32'h5000, 0, 0, 0, "R3 br");
        cyc(1, 0, 0, 0, 0, 1, "R3 slot halt");
        chk("R3 slot kept", {31'd0, in_delay_slot}, 32'd1);
        cyc(1, 0, 0, 0, 0, 1, "R3 slot step");
        chk("R3 target after halt", fetch_addr, 32'h5000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule